// File: doc/BRIEF.md
# Burst-Limited FIFO Transfer Chunker

This block moves a byte stream of any length into or out of a target device's data FIFO register. It issues register transactions through a simple transaction port, and each transaction is kept no larger than the burst allowance that the target currently advertises. Before every chunk the chunker reads the target's 32-bit status register and takes the burst allowance from it. It then sizes the chunk as the smallest of three values: the bytes still outstanding, that allowance and 64. Last, it issues one FIFO read or FIFO write of that size. The serial signalling beneath the transaction port belongs to another block.

A caller starts a transfer with a direction and a byte count, and later receives a single completion pulse that carries an error flag. In the write direction the stream bytes pass straight through to the target, one byte for each byte the target takes. In the read direction the FIFO bytes returned by the target appear on the receive stream. Status bytes never appear on it. If the target stays busy too long or rejects a FIFO transaction, the whole transfer ends with an error.

Transaction-port protocol: a command is presented on `cmd_valid` with address, length and direction, and it is taken on a cycle where `cmd_ready` is high. The data bytes follow, one per cycle in which `rd_valid` or `wr_take` is high. `txn_done` then pulses for one cycle after the last data byte, with `txn_err` giving the outcome.

Top module: `fifo_chunker`

## Requirements
- R1: Before every chunk the block issues a status command: address 0x18, length 4, `cmd_write`=0. It forms a 32-bit word from the four returned bytes, first byte least significant. The burst allowance is word bits 23:8, so byte 1 is its low half and byte 2 its high half. Bits 7:0 and 31:24 have no effect.
- R2: A burst allowance of zero causes another status command, and no FIFO command is issued in between.
- R3: Each FIFO command length equals min(bytes remaining, burst allowance, 64). It is never zero.
- R4: Every chunk command targets address 0x24. For `req_dir`=0 (write) `cmd_write`=1, each target-taken byte equals `tx_data`, and `tx_ready` marks that byte. For `req_dir`=1 (read) `cmd_write`=0 and each returned FIFO byte appears on `rx_data` with `rx_valid`. `rx_valid` stays low while status bytes arrive.
- R5: A FIFO transaction that ends with `txn_err`=1 ends the transfer with `done`=1 and `done_err`=1. No further command follows.
- R6: When the bytes moved equal `req_len`, `done` pulses for one cycle with `done_err`=0, and `req_ready` is high the next cycle.
- R7: A request with `req_len`=0 produces `done`=1, `done_err`=0 in the cycle after acceptance, with no command.
- R8: `MAX_POLLS` consecutive status reads that return zero end the transfer with `done_err`=1 and no FIFO command. The count restarts after every nonzero allowance.
- R9: A status command that ends with `txn_err`=1 counts as a busy (zero) poll.
- R10: Once raised, `cmd_valid` together with the address, length and direction hold steady until `cmd_ready` takes the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Block idle, request accepted |
| req_dir | input | 1 | 0 = stream to target, 1 = target to stream |
| req_len | input | LEN_W | Transfer length in bytes |
| tx_data | input | 8 | Outgoing stream byte, valid while a write transfer runs |
| tx_ready | output | 1 | Current outgoing byte consumed |
| rx_data | output | 8 | Incoming stream byte |
| rx_valid | output | 1 | Incoming byte valid |
| cmd_valid | output | 1 | Register command valid |
| cmd_ready | input | 1 | Register command taken |
| cmd_write | output | 1 | Command is a write |
| cmd_addr | output | ADDR_W | Register address |
| cmd_len | output | CHUNK_W | Command byte count |
| wr_data | output | 8 | Byte offered to a write command |
| wr_take | input | 1 | Target takes `wr_data` |
| rd_data | input | 8 | Byte returned by a read command |
| rd_valid | input | 1 | `rd_data` valid |
| txn_done | input | 1 | Command finished |
| txn_err | input | 1 | Command failed (with `txn_done`) |
| done | output | 1 | Transfer finished, one-cycle pulse |
| done_err | output | 1 | Transfer failed (with `done`) |

## Verification
The bench builds the block with a 10-bit length and a poll limit of 4, and leaves the 64-byte cap and 16-bit allowance at their defaults. A poll limit of 4 lets a few scripted zero reads reach the busy-timeout path quickly, and lets the bench show that a nonzero allowance between runs of three zeros restarts the count. Allowances above 64, one that fits only in the upper status byte, and one below the remaining count bring each of the three limits of the minimum into play within a 100-byte transfer.

// File: rtl/fifo_chunker_pkg.sv
package fifo_chunker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STS_REQ,
    ST_STS_DATA,
    ST_EVAL,
    ST_FIFO_REQ,
    ST_FIFO_DATA,
    ST_DONE
  } chk_state_e;

  localparam int STS_BYTES = 4;

endpackage

// File: rtl/chunk_status_capture.sv
module chunk_status_capture #(
  parameter int BURST_LSB = 8,
  parameter int BURST_W   = 16,
  parameter int LANES     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               byte_valid,
  input  logic [7:0]         byte_in,
  output logic [BURST_W-1:0] burst
);
  localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int WORD_W = 8 * LANES;

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] word;

  always_comb begin
    idx_d = idx_q;
    if (clear)           idx_d = '0;
    else if (byte_valid) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  // Only lanes overlapping the burst field get storage.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if ((8*g + 7 >= BURST_LSB) && (8*g <= BURST_LSB + BURST_W - 1)) begin : g_keep
      logic [7:0] lane_q, lane_d;
      logic       lane_en;
      assign lane_en = clear || (byte_valid && (idx_q == IDX_W'(g)));
      always_comb lane_d = clear ? 8'h00 : byte_in;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lane_q <= 8'h00;
        else if (lane_en) lane_q <= lane_d;
      end
      assign word[8*g +: 8] = lane_q;
    end else begin : g_drop
      assign word[8*g +: 8] = 8'h00;
    end
  end

  assign burst = word[BURST_LSB +: BURST_W];

endmodule

// File: rtl/chunk_size_min.sv
module chunk_size_min #(
  parameter int LEN_W     = 16,
  parameter int BURST_W   = 16,
  parameter int MAX_CHUNK = 64,
  parameter int CHUNK_W   = 7
) (
  input  logic [LEN_W-1:0]   remain,
  input  logic [BURST_W-1:0] burst,
  output logic [CHUNK_W-1:0] chunk
);
  localparam int BASE_W = (LEN_W > BURST_W) ? LEN_W : BURST_W;
  localparam int CMP_W  = ((BASE_W > CHUNK_W) ? BASE_W : CHUNK_W) + 1;

  logic [CMP_W-1:0] a, b, c, m1, m2;

  always_comb begin
    a     = CMP_W'(remain);
    b     = CMP_W'(burst);
    c     = CMP_W'(MAX_CHUNK);
    m1    = (a < b) ? a : b;
    m2    = (m1 < c) ? m1 : c;
    chunk = m2[CHUNK_W-1:0];
  end

endmodule

// File: rtl/chunk_poll_limit.sv
module chunk_poll_limit #(
  parameter int MAX_POLLS = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic expire
);
  localparam int PC_W = $clog2(MAX_POLLS + 1);

  logic [PC_W-1:0] cnt_q, cnt_d;

  assign expire = step && (cnt_q == PC_W'(MAX_POLLS - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fifo_chunker.sv
module fifo_chunker
  import fifo_chunker_pkg::*;
#(
  parameter int              LEN_W     = 16,
  parameter int              ADDR_W    = 24,
  parameter int              BURST_LSB = 8,
  parameter int              BURST_W   = 16,
  parameter int              MAX_CHUNK = 64,
  parameter int              MAX_POLLS = 100000,
  parameter logic [ADDR_W-1:0] STS_ADDR  = ADDR_W'(24'h000018),
  parameter logic [ADDR_W-1:0] FIFO_ADDR = ADDR_W'(24'h000024),
  localparam int             CHUNK_W   = $clog2(MAX_CHUNK + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_dir,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [7:0]         tx_data,
  output logic               tx_ready,
  output logic [7:0]         rx_data,
  output logic               rx_valid,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic               cmd_write,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic [CHUNK_W-1:0] cmd_len,
  output logic [7:0]         wr_data,
  input  logic               wr_take,
  input  logic [7:0]         rd_data,
  input  logic               rd_valid,
  input  logic               txn_done,
  input  logic               txn_err,
  output logic               done,
  output logic               done_err
);

  chk_state_e         state_q, state_d;
  logic [LEN_W-1:0]   remain_q, remain_d;
  logic [CHUNK_W-1:0] chunk_q, chunk_d;
  logic               dir_q, dir_d;
  logic               err_q, err_d;

  logic               remain_en, chunk_en, dir_en, err_en;
  logic [BURST_W-1:0] burst;
  logic [CHUNK_W-1:0] chunk_calc;
  logic               cap_clear, cap_valid;
  logic               poll_clear, poll_step, poll_expire;

  chunk_status_capture #(
    .BURST_LSB(BURST_LSB),
    .BURST_W  (BURST_W),
    .LANES    (STS_BYTES)
  ) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cap_clear),
    .byte_valid(cap_valid),
    .byte_in   (rd_data),
    .burst     (burst)
  );

  chunk_size_min #(
    .LEN_W    (LEN_W),
    .BURST_W  (BURST_W),
    .MAX_CHUNK(MAX_CHUNK),
    .CHUNK_W  (CHUNK_W)
  ) u_sizer (
    .remain(remain_q),
    .burst (burst),
    .chunk (chunk_calc)
  );

  chunk_poll_limit #(
    .MAX_POLLS(MAX_POLLS)
  ) u_polls (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (poll_clear),
    .step  (poll_step),
    .expire(poll_expire)
  );

  assign cap_clear  = (state_q == ST_STS_REQ);
  assign cap_valid  = (state_q == ST_STS_DATA) && rd_valid;
  assign poll_step  = ((state_q == ST_STS_DATA) && txn_done && txn_err) ||
                      ((state_q == ST_EVAL) && (burst == '0));
  assign poll_clear = ((state_q == ST_IDLE) && req_valid) ||
                      ((state_q == ST_EVAL) && (burst != '0));

  // Output decode
  always_comb begin
    req_ready = (state_q == ST_IDLE);
    cmd_valid = 1'b0;
    cmd_write = 1'b0;
    cmd_addr  = STS_ADDR;
    cmd_len   = CHUNK_W'(STS_BYTES);
    case (state_q)
      ST_STS_REQ: cmd_valid = 1'b1;
      ST_FIFO_REQ: begin
        cmd_valid = 1'b1;
        cmd_write = !dir_q;
        cmd_addr  = FIFO_ADDR;
        cmd_len   = chunk_q;
      end
      default: ;
    endcase
    wr_data  = tx_data;
    tx_ready = (state_q == ST_FIFO_DATA) && !dir_q && wr_take;
    rx_data  = rd_data;
    rx_valid = (state_q == ST_FIFO_DATA) && dir_q && rd_valid;
    done     = (state_q == ST_DONE);
    done_err = (state_q == ST_DONE) && err_q;
  end

  // Next state
  always_comb begin
    state_d   = state_q;
    remain_d  = remain_q;
    chunk_d   = chunk_q;
    dir_d     = dir_q;
    err_d     = err_q;
    remain_en = 1'b0;
    chunk_en  = 1'b0;
    dir_en    = 1'b0;
    err_en    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          dir_d     = req_dir;
          dir_en    = 1'b1;
          remain_d  = req_len;
          remain_en = 1'b1;
          err_d     = 1'b0;
          err_en    = 1'b1;
          state_d   = (req_len == '0) ? ST_DONE : ST_STS_REQ;
        end
      end
      ST_STS_REQ: begin
        if (cmd_ready) state_d = ST_STS_DATA;
      end
      ST_STS_DATA: begin
        if (txn_done) begin
          if (!txn_err) begin
            state_d = ST_EVAL;
          end else if (poll_expire) begin
            err_d   = 1'b1;
            err_en  = 1'b1;
            state_d = ST_DONE;
          end else begin
            state_d = ST_STS_REQ;
          end
        end
      end
      ST_EVAL: begin
        if (burst != '0) begin
          chunk_d  = chunk_calc;
          chunk_en = 1'b1;
          state_d  = ST_FIFO_REQ;
        end else if (poll_expire) begin
          err_d   = 1'b1;
          err_en  = 1'b1;
          state_d = ST_DONE;
        end else begin
          state_d = ST_STS_REQ;
        end
      end
      ST_FIFO_REQ: begin
        if (cmd_ready) state_d = ST_FIFO_DATA;
      end
      ST_FIFO_DATA: begin
        if (txn_done) begin
          if (txn_err) begin
            err_d   = 1'b1;
            err_en  = 1'b1;
            state_d = ST_DONE;
          end else begin
            remain_d  = remain_q - LEN_W'(chunk_q);
            remain_en = 1'b1;
            state_d   = (remain_q == LEN_W'(chunk_q)) ? ST_DONE : ST_STS_REQ;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         remain_q <= '0;
    else if (remain_en) remain_q <= remain_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chunk_q <= '0;
    else if (chunk_en) chunk_q <= chunk_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= 1'b0;
    else if (dir_en) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

endmodule

// File: rtl/fifo_chunker_chk.sv
module fifo_chunker_chk #(
  parameter int                LEN_W     = 16,
  parameter int                ADDR_W    = 24,
  parameter int                MAX_CHUNK = 64,
  parameter int                CHUNK_W   = 7,
  parameter logic [ADDR_W-1:0] STS_ADDR  = '0,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [LEN_W-1:0]   req_len,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic               cmd_write,
  input logic [ADDR_W-1:0]  cmd_addr,
  input logic [CHUNK_W-1:0] cmd_len,
  input logic               done,
  input logic               done_err
);

  assert_sts_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_addr == STS_ADDR) |-> (!cmd_write && cmd_len == CHUNK_W'(4)));

  assert_chunk_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_addr == FIFO_ADDR) |->
      (cmd_len != '0 && cmd_len <= CHUNK_W'(MAX_CHUNK)));

  assert_cmd_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_addr == STS_ADDR || cmd_addr == FIFO_ADDR));

  assert_idle_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len == '0) |=> (done && !done_err && !cmd_valid));

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_write)));

endmodule

bind fifo_chunker fifo_chunker_chk #(
  .LEN_W    (LEN_W),
  .ADDR_W   (ADDR_W),
  .MAX_CHUNK(MAX_CHUNK),
  .CHUNK_W  (CHUNK_W),
  .STS_ADDR (STS_ADDR),
  .FIFO_ADDR(FIFO_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_len  (req_len),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_write(cmd_write),
  .cmd_addr (cmd_addr),
  .cmd_len  (cmd_len),
  .done     (done),
  .done_err (done_err)
);

// File: tb/fifo_chunker_tb.sv
module fifo_chunker_tb;
  localparam int LEN_W   = 10;
  localparam int ADDR_W  = 24;
  localparam int CHUNK_W = 7;

  logic               clk;
  logic               rst_n;
  logic               req_valid;
  logic               req_ready;
  logic               req_dir;
  logic [LEN_W-1:0]   req_len;
  logic [7:0]         tx_data;
  logic               tx_ready;
  logic [7:0]         rx_data;
  logic               rx_valid;
  logic               cmd_valid;
  logic               cmd_ready;
  logic               cmd_write;
  logic [ADDR_W-1:0]  cmd_addr;
  logic [CHUNK_W-1:0] cmd_len;
  logic [7:0]         wr_data;
  logic               wr_take;
  logic [7:0]         rd_data;
  logic               rd_valid;
  logic               txn_done;
  logic               txn_err;
  logic               done;
  logic               done_err;

  fifo_chunker #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .MAX_POLLS(4)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_dir(req_dir), .req_len(req_len),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .txn_done(txn_done), .txn_err(txn_err), .done(done), .done_err(done_err)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // target script and log
  int burst_s [16];
  bit sts_err_s [16];
  int fail_at;
  int n_sts, n_fifo, n_w, n_r, bad_cmd, bad_hold, rx_leak, bad_tx, src_idx;
  int fifo_len [16];
  int fifo_wr [16];
  logic [7:0] wcap [128];
  logic [7:0] rcap [128];
  bit got_err;

  function automatic logic [7:0] wpat(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] rpat(int i);
    return 8'((i * 13 + 1) & 255);
  endfunction

  assign tx_data = wpat(src_idx);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  task automatic clear_log();
    for (int i = 0; i < 16; i++) begin
      burst_s[i] = 0; sts_err_s[i] = 0; fifo_len[i] = 0; fifo_wr[i] = 0;
    end
    fail_at = -1;
    n_sts = 0; n_fifo = 0; n_w = 0; n_r = 0;
    bad_cmd = 0; bad_hold = 0; rx_leak = 0; bad_tx = 0; src_idx = 0;
  endtask

  task automatic target_model();
    logic [ADDR_W-1:0] a;
    int l, b;
    bit w, e;
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        a = cmd_addr; l = int'(cmd_len); w = cmd_write;
        if (((n_sts + n_fifo) % 2) == 1) begin
          @(negedge clk);
          if (!cmd_valid || cmd_addr != a || int'(cmd_len) != l) bad_hold++;
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        if (a == 24'h18) begin
          if (w || l != 4) bad_cmd++;
          b = burst_s[n_sts]; e = sts_err_s[n_sts]; n_sts++;
          for (int k = 0; k < 4; k++) begin
            case (k)
              0: rd_data = 8'hA5;
              1: rd_data = 8'(b & 255);
              2: rd_data = 8'((b >> 8) & 255);
              default: rd_data = 8'h3C;
            endcase
            rd_valid = 1'b1;
            #1;
            if (rx_valid) rx_leak++;
            @(negedge clk);
          end
          rd_valid = 1'b0;
        end else begin
          if (a != 24'h24) bad_cmd++;
          fifo_len[n_fifo] = l; fifo_wr[n_fifo] = w;
          e = (n_fifo == fail_at); n_fifo++;
          for (int k = 0; k < l; k++) begin
            if (w) begin
              wr_take = 1'b1;
              #1;
              if (!tx_ready) bad_tx++;
              wcap[n_w] = wr_data; n_w++;
              @(negedge clk);
              src_idx++;
            end else begin
              rd_data = rpat(n_r); rd_valid = 1'b1;
              #1;
              rcap[n_r] = rx_valid ? rx_data : ~rpat(n_r); n_r++;
              @(negedge clk);
            end
          end
          wr_take = 1'b0; rd_valid = 1'b0;
        end
        txn_done = 1'b1; txn_err = e;
        @(negedge clk);
        txn_done = 1'b0; txn_err = 1'b0;
      end
    end
  endtask

  task automatic start(bit dir, int len);
    @(negedge clk);
    req_valid = 1'b1; req_dir = dir; req_len = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(done == 1'b1, "R6 done timeout", int'(done), 1);
    got_err = done_err;
    @(negedge clk);
    check(req_ready == 1'b1 && done == 1'b0, "R6 idle after done", int'(req_ready), 1);
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "reset req_ready", int'(req_ready), 1);
    check(cmd_valid == 1'b0 && done == 1'b0, "reset outputs", int'(cmd_valid), 0);
  endtask

  // R1 R3 R4: write 100 bytes, allowances 256 (upper byte only), 30, 200
  task automatic t_write_split();
    int bad = 0;
    clear_log();
    burst_s[0] = 256; burst_s[1] = 30; burst_s[2] = 200;
    start(1'b0, 100);
    wait_done();
    check(!got_err, "R6 write ok", int'(got_err), 0);
    check(n_sts == 3, "R1 status reads", n_sts, 3);
    check(n_fifo == 3 && fifo_len[0] == 64, "R3 chunk0 cap 64", fifo_len[0], 64);
    check(fifo_len[1] == 30, "R3 chunk1 burst", fifo_len[1], 30);
    check(fifo_len[2] == 6, "R3 chunk2 remaining", fifo_len[2], 6);
    check(fifo_wr[0] == 1 && fifo_wr[2] == 1, "R4 write dir", fifo_wr[0], 1);
    for (int i = 0; i < 100; i++) if (wcap[i] != wpat(i)) bad++;
    check(n_w == 100 && bad == 0, "R4 write data", bad, 0);
    check(bad_cmd == 0 && bad_tx == 0, "R4 addresses and tx_ready", bad_cmd + bad_tx, 0);
    check(bad_hold == 0, "R10 command hold", bad_hold, 0);
  endtask

  // R2 R8: read 4 bytes, zeros interleaved below the limit
  task automatic t_read_polls();
    int bad = 0;
    clear_log();
    burst_s[0] = 0; burst_s[1] = 0; burst_s[2] = 0; burst_s[3] = 2;
    burst_s[4] = 0; burst_s[5] = 0; burst_s[6] = 0; burst_s[7] = 5;
    start(1'b1, 4);
    wait_done();
    check(!got_err, "R8 count restarts", int'(got_err), 0);
    check(n_sts == 8, "R2 repoll count", n_sts, 8);
    check(n_fifo == 2 && fifo_len[0] == 2 && fifo_len[1] == 2, "R2 chunks", fifo_len[1], 2);
    for (int i = 0; i < 4; i++) if (rcap[i] != rpat(i)) bad++;
    check(n_r == 4 && bad == 0, "R4 read data", bad, 0);
    check(rx_leak == 0 && fifo_wr[0] == 0, "R4 status bytes hidden", rx_leak, 0);
  endtask

  task automatic t_zero_len();
    clear_log();
    start(1'b0, 0);
    check(done == 1'b1 && done_err == 1'b0, "R7 zero length done", int'(done), 1);
    @(negedge clk);
    repeat (3) @(negedge clk);
    check(n_sts == 0 && n_fifo == 0, "R7 no command", n_sts + n_fifo, 0);
  endtask

  task automatic t_poll_timeout();
    clear_log();
    start(1'b0, 8);
    wait_done();
    check(got_err, "R8 timeout error", int'(got_err), 1);
    check(n_sts == 4 && n_fifo == 0, "R8 reads before timeout", n_sts, 4);
  endtask

  task automatic t_fifo_error();
    clear_log();
    for (int i = 0; i < 8; i++) burst_s[i] = 8;
    fail_at = 1;
    start(1'b0, 20);
    wait_done();
    check(got_err, "R5 fifo error", int'(got_err), 1);
    repeat (4) @(negedge clk);
    check(n_fifo == 2 && n_sts == 2, "R5 no further command", n_sts, 2);
  endtask

  task automatic t_sts_error();
    clear_log();
    burst_s[0] = 5; sts_err_s[0] = 1; burst_s[1] = 5;
    start(1'b1, 3);
    wait_done();
    check(!got_err && n_sts == 2, "R9 failed status repolled", n_sts, 2);
    check(n_fifo == 1 && fifo_len[0] == 3, "R9 chunk after retry", fifo_len[0], 3);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_dir = 1'b0; req_len = '0;
    cmd_ready = 1'b0; wr_take = 1'b0; rd_data = 8'h00; rd_valid = 1'b0;
    txn_done = 1'b0; txn_err = 1'b0;
    clear_log();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      target_model();
    join_none
    t_reset();
    t_write_split();
    t_read_polls();
    t_zero_len();
    t_poll_timeout();
    t_fifo_error();
    t_sts_error();
    summary();
  end

endmodule